// File: doc/BRIEF.md
# Interrupt and Trap Entry Controller

This block keeps the interrupt state of a single core and performs trap entry for it. It holds an eight-bit vector of pending interrupt requests. Bit 7 is raised by a count/compare timer and bit 5 by an inter-processor interrupt (IPI). Any bit can also be raised or cleared through per-bit strobes from the control register file. Every cycle the vector is masked with the interrupt-mask field of the status word. If the core is running, traps are enabled and some masked bit is set, the block takes the lowest-numbered surviving request.

Trap entry is a single clock edge. The status word moves to supervisor mode with traps disabled and the previous-supervisor bit saved. The current PC goes to the exception PC and the PC is loaded from the exception vector. The cause register receives a code that is unique to each interrupt line. The faulting address input is captured into the bad-address register.

Out of reset the vector points at 0x2000 and traps are already enabled. The first IPI that arrives therefore starts the core by trapping it to 0x2000.

Top module: `irq_trap_ctrl`

## Requirements
- R1: On reset the status word is 0xFFB, the exception vector is 0x2000, and the PC, exception PC, cause, bad address, count, compare and pending vector are zero, with the core not running. Status layout: bit0 trap-enable, bit1 supervisor, bit2 previous-supervisor, bit3 64-bit supervisor, bits 11:4 interrupt mask.
- R2: A pulse on `ipi_deliver` sets pending bit 5 and the running flag at the next edge. The running flag never clears again until reset.
- R3: `trap_take` is high exactly when the core is running, status bit0 is set and the pending vector ANDed with status bits 11:4 is nonzero.
- R4: On trap entry the cause register receives IRQ_BASE plus the index of the lowest-numbered set bit of the masked pending vector.
- R5: On trap entry status bit1 becomes 1, bit0 becomes 0, bit2 takes the old bit1, and bits 11:3 are unchanged.
- R6: On trap entry the exception PC takes the current PC, the PC takes the exception vector, and the bad address takes `fault_addr`.
- R7: With no count write in the cycle, pending bit 7 is set when the old count is below compare and the old count plus `cnt_step`, computed one bit wider, is greater than or equal to compare. This includes steps that jump past compare or wrap the count.
- R8: A write to compare loads it and clears pending bit 7. A bit of `irq_clr` clears that pending bit (bit 5 is the IPI clear). A set and a clear of the same bit in one cycle leave it set.
- R9: Pending bits never clear except through R8, including while they are masked or while traps are disabled.
- R10: When no trap is taken, writes to status and PC take effect at the next edge. In a cycle with `trap_take` high, trap entry overrides both writes. Exception vector writes always take effect.
- R11: The count loads `cnt_wdata` when `cnt_wr` is high and otherwise advances by `cnt_step`, modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_step | input | STEP_W | Count increment for this cycle |
| cnt_wr | input | 1 | Load the count |
| cnt_wdata | input | CNT_W | New count value |
| cmp_wr | input | 1 | Load compare and clear timer request |
| cmp_wdata | input | CNT_W | New compare value |
| irq_set | input | 8 | Per-bit pending set strobes |
| irq_clr | input | 8 | Per-bit pending clear strobes |
| ipi_deliver | input | 1 | Inter-processor interrupt arrival |
| status_wr | input | 1 | Write the status word |
| status_wdata | input | 12 | New status word |
| evec_wr | input | 1 | Write the exception vector |
| evec_wdata | input | XLEN | New exception vector |
| pc_upd | input | 1 | Core advances the PC |
| pc_next | input | XLEN | Next PC from the core |
| fault_addr | input | XLEN | Address captured on trap entry |
| trap_take | output | 1 | Trap entry happens at this edge |
| pending_q | output | 8 | Pending interrupt vector |
| status_q | output | 12 | Status word |
| pc_q | output | XLEN | Program counter |
| epc_q | output | XLEN | Exception PC |
| cause_q | output | CAUSE_W | Trap cause |
| badaddr_q | output | XLEN | Bad address |
| evec_q | output | XLEN | Exception vector |
| count_q | output | CNT_W | Timer count |
| running | output | 1 | Core has been started by an IPI |

## Verification
The assertions assume that every input is a known value from the first edge after reset. They also assume that `cnt_step` is fed unsigned with no meaning attached to its upper bits.

The bench drives all inputs on the falling edge from a seeded generator and from directed cases. Status words are drawn over the full 12-bit range, so traps turn on and off freely. Compare values are placed a short distance above the live count so that crossings actually happen. Directed cases cover the timer exact-hit, equal-start, jump-past and wrap crossings, simultaneous set and clear, and writes that collide with trap entry.

// File: rtl/irq_trap_pkg.sv
package irq_trap_pkg;
    localparam int NUM_IRQ   = 8;
    localparam int IDX_W     = $clog2(NUM_IRQ);
    localparam int TIMER_IRQ = 7;
    localparam int IPI_IRQ   = 5;

    typedef struct packed {
        logic [NUM_IRQ-1:0] im;
        logic               sx;
        logic               ps;
        logic               s;
        logic               et;
    } status_t;

    localparam int ST_W = $bits(status_t);

    localparam status_t STATUS_RESET = '{im: {NUM_IRQ{1'b1}}, sx: 1'b1,
                                         ps: 1'b0, s: 1'b1, et: 1'b1};

    typedef struct packed {
        logic             take;
        logic [IDX_W-1:0] idx;
    } irq_sel_t;

    function automatic status_t enter_trap(status_t cur);
        status_t r;
        r    = cur;
        r.ps = cur.s;
        r.s  = 1'b1;
        r.et = 1'b0;
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] lowest_set(logic [NUM_IRQ-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--)
            if (v[i]) r = IDX_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/irq_timer.sv
module irq_timer #(
    parameter int CNT_W  = 32,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STEP_W-1:0] step,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              cmp_wr,
    input  logic [CNT_W-1:0]  cmp_wdata,
    output logic [CNT_W-1:0]  count_q,
    output logic              fire
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cmp_q;
    logic [SUM_W-1:0] sum;

    assign sum  = {1'b0, count_q} + SUM_W'(step);
    assign fire = !cnt_wr && (count_q < cmp_q) && (sum >= {1'b0, cmp_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            cmp_q   <= '0;
        end else begin
            count_q <= cnt_wr ? cnt_wdata : sum[CNT_W-1:0];
            if (cmp_wr) cmp_q <= cmp_wdata;
        end
    end
endmodule

// File: rtl/irq_pending.sv
module irq_pending
    import irq_trap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] set_vec,
    input  logic [NUM_IRQ-1:0] clr_vec,
    input  logic [NUM_IRQ-1:0] mask,
    input  logic               enable,
    input  logic               running,
    output logic [NUM_IRQ-1:0] pending_q,
    output irq_sel_t           sel
);
    logic [NUM_IRQ-1:0] live;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)             pending_q[i] <= 1'b0;
            else if (set_vec[i]) pending_q[i] <= 1'b1;
            else if (clr_vec[i]) pending_q[i] <= 1'b0;
        end
    end

    assign live     = pending_q & mask;
    assign sel.take = running && enable && (|live);
    assign sel.idx  = lowest_set(live);
endmodule

// File: rtl/irq_trap_state.sv
module irq_trap_state
    import irq_trap_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter int              CAUSE_W   = 8,
    parameter int              IRQ_BASE  = 16,
    parameter logic [XLEN-1:0] RESET_VEC = XLEN'(32'h2000)
) (
    input  logic               clk,
    input  logic               rst,
    input  irq_sel_t           sel,
    input  logic               ipi_deliver,
    input  logic               status_wr,
    input  status_t            status_wdata,
    input  logic               evec_wr,
    input  logic [XLEN-1:0]    evec_wdata,
    input  logic               pc_upd,
    input  logic [XLEN-1:0]    pc_next,
    input  logic [XLEN-1:0]    fault_addr,
    output status_t            status_q,
    output logic [XLEN-1:0]    pc_q,
    output logic [XLEN-1:0]    epc_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [XLEN-1:0]    badaddr_q,
    output logic [XLEN-1:0]    evec_q,
    output logic               running_q
);
    localparam logic [CAUSE_W-1:0] BASE_CODE = CAUSE_W'(IRQ_BASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q  <= STATUS_RESET;
            pc_q      <= '0;
            epc_q     <= '0;
            cause_q   <= '0;
            badaddr_q <= '0;
            evec_q    <= RESET_VEC;
            running_q <= 1'b0;
        end else begin
            if (ipi_deliver) running_q <= 1'b1;
            if (evec_wr)     evec_q    <= evec_wdata;
            if (sel.take) begin
                status_q  <= enter_trap(status_q);
                epc_q     <= pc_q;
                pc_q      <= evec_q;
                cause_q   <= BASE_CODE + CAUSE_W'(sel.idx);
                badaddr_q <= fault_addr;
            end else begin
                if (status_wr) status_q <= status_wdata;
                if (pc_upd)    pc_q     <= pc_next;
            end
        end
    end
endmodule

// File: rtl/irq_trap_ctrl.sv
module irq_trap_ctrl
    import irq_trap_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter int              CNT_W     = 32,
    parameter int              STEP_W    = 8,
    parameter int              CAUSE_W   = 8,
    parameter int              IRQ_BASE  = 16,
    parameter logic [XLEN-1:0] RESET_VEC = XLEN'(32'h2000)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STEP_W-1:0]  cnt_step,
    input  logic               cnt_wr,
    input  logic [CNT_W-1:0]   cnt_wdata,
    input  logic               cmp_wr,
    input  logic [CNT_W-1:0]   cmp_wdata,
    input  logic [7:0]         irq_set,
    input  logic [7:0]         irq_clr,
    input  logic               ipi_deliver,
    input  logic               status_wr,
    input  logic [11:0]        status_wdata,
    input  logic               evec_wr,
    input  logic [XLEN-1:0]    evec_wdata,
    input  logic               pc_upd,
    input  logic [XLEN-1:0]    pc_next,
    input  logic [XLEN-1:0]    fault_addr,
    output logic               trap_take,
    output logic [7:0]         pending_q,
    output logic [11:0]        status_q,
    output logic [XLEN-1:0]    pc_q,
    output logic [XLEN-1:0]    epc_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [XLEN-1:0]    badaddr_q,
    output logic [XLEN-1:0]    evec_q,
    output logic [CNT_W-1:0]   count_q,
    output logic               running
);
    logic               tmr_fire;
    logic [NUM_IRQ-1:0] set_vec;
    logic [NUM_IRQ-1:0] clr_vec;
    status_t            st;
    irq_sel_t           sel;

    assign set_vec = irq_set
                   | (NUM_IRQ'(tmr_fire)    << TIMER_IRQ)
                   | (NUM_IRQ'(ipi_deliver) << IPI_IRQ);
    assign clr_vec = irq_clr | (NUM_IRQ'(cmp_wr) << TIMER_IRQ);

    irq_timer #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .step      (cnt_step),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .count_q   (count_q),
        .fire      (tmr_fire)
    );

    irq_pending u_pend (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .mask      (st.im),
        .enable    (st.et),
        .running   (running),
        .pending_q (pending_q),
        .sel       (sel)
    );

    irq_trap_state #(
        .XLEN(XLEN), .CAUSE_W(CAUSE_W), .IRQ_BASE(IRQ_BASE), .RESET_VEC(RESET_VEC)
    ) u_state (
        .clk          (clk),
        .rst          (rst),
        .sel          (sel),
        .ipi_deliver  (ipi_deliver),
        .status_wr    (status_wr),
        .status_wdata (status_t'(status_wdata)),
        .evec_wr      (evec_wr),
        .evec_wdata   (evec_wdata),
        .pc_upd       (pc_upd),
        .pc_next      (pc_next),
        .fault_addr   (fault_addr),
        .status_q     (st),
        .pc_q         (pc_q),
        .epc_q        (epc_q),
        .cause_q      (cause_q),
        .badaddr_q    (badaddr_q),
        .evec_q       (evec_q),
        .running_q    (running)
    );

    assign status_q  = st;
    assign trap_take = sel.take;
endmodule

// File: rtl/irq_trap_ctrl_chk.sv
module irq_trap_ctrl_chk #(
    parameter int XLEN     = 64,
    parameter int CAUSE_W  = 8,
    parameter int IRQ_BASE = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               trap_take,
    input logic               ipi_deliver,
    input logic               cmp_wr,
    input logic [7:0]         irq_clr,
    input logic [7:0]         pending_q,
    input logic [11:0]        status_q,
    input logic [XLEN-1:0]    pc_q,
    input logic [XLEN-1:0]    epc_q,
    input logic [XLEN-1:0]    evec_q,
    input logic [XLEN-1:0]    badaddr_q,
    input logic [XLEN-1:0]    fault_addr,
    input logic [CAUSE_W-1:0] cause_q,
    input logic               running
);
    logic [CAUSE_W-1:0] cause_rel;
    assign cause_rel = cause_q - CAUSE_W'(IRQ_BASE);

    p_ipi_start_r2: assert property (@(posedge clk) disable iff (rst)
        ipi_deliver |=> pending_q[5] && running);

    p_idle_no_trap_r3: assert property (@(posedge clk) disable iff (rst)
        !running |-> !trap_take);

    p_disabled_no_trap_r3: assert property (@(posedge clk) disable iff (rst)
        !status_q[0] |-> !trap_take);

    p_cause_window_r4: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> cause_rel < CAUSE_W'(8));

    p_entry_status_r5: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> !status_q[0] && status_q[1]
                      && status_q[2] == $past(status_q[1])
                      && status_q[11:3] == $past(status_q[11:3]));

    p_entry_redirect_r6: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> pc_q == $past(evec_q) && epc_q == $past(pc_q)
                      && badaddr_q == $past(fault_addr));

    p_ipi_hold_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(pending_q[5]) |-> $past(irq_clr[5]));

    p_timer_hold_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(pending_q[7]) |-> $past(irq_clr[7] || cmp_wr));
endmodule

bind irq_trap_ctrl irq_trap_ctrl_chk #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .IRQ_BASE(IRQ_BASE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .trap_take   (trap_take),
    .ipi_deliver (ipi_deliver),
    .cmp_wr      (cmp_wr),
    .irq_clr     (irq_clr),
    .pending_q   (pending_q),
    .status_q    (status_q),
    .pc_q        (pc_q),
    .epc_q       (epc_q),
    .evec_q      (evec_q),
    .badaddr_q   (badaddr_q),
    .fault_addr  (fault_addr),
    .cause_q     (cause_q),
    .running     (running)
);

// File: tb/irq_trap_ctrl_bench.sv
`timescale 1ns/1ps
module irq_trap_ctrl_bench;
    localparam int XLEN = 64, CNT_W = 32, STEP_W = 8, CAUSE_W = 8, BASE = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [STEP_W-1:0]  cnt_step = '0;
    logic               cnt_wr = 1'b0;
    logic [CNT_W-1:0]   cnt_wdata = '0;
    logic               cmp_wr = 1'b0;
    logic [CNT_W-1:0]   cmp_wdata = '0;
    logic [7:0]         irq_set = '0, irq_clr = '0;
    logic               ipi_deliver = 1'b0;
    logic               status_wr = 1'b0;
    logic [11:0]        status_wdata = '0;
    logic               evec_wr = 1'b0;
    logic [XLEN-1:0]    evec_wdata = '0;
    logic               pc_upd = 1'b0;
    logic [XLEN-1:0]    pc_next = '0, fault_addr = '0;
    logic               trap_take, running;
    logic [7:0]         pending_q;
    logic [11:0]        status_q;
    logic [XLEN-1:0]    pc_q, epc_q, badaddr_q, evec_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [CNT_W-1:0]   count_q;

    irq_trap_ctrl u_irq_trap_ctrl (.*);

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // bench-side expected state
    logic [7:0]       m_pend;
    logic [11:0]      m_st;
    logic [XLEN-1:0]  m_pc, m_epc, m_bad, m_evec;
    logic [7:0]       m_cause;
    logic [CNT_W-1:0] m_cnt, m_cmp;
    logic             m_run;

    function automatic int low_idx(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic logic exp_take();
        return m_run && m_st[0] && ((m_pend & m_st[11:4]) != 8'h0);
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3", "trap_take", 64'(trap_take), 64'(exp_take()));
        chk("R9", "pending", 64'(pending_q), 64'(m_pend));
        chk("R5", "status", 64'(status_q), 64'(m_st));
        chk("R6", "pc", pc_q, m_pc);
        chk("R6", "epc", epc_q, m_epc);
        chk("R6", "badaddr", badaddr_q, m_bad);
        chk("R4", "cause", 64'(cause_q), 64'(m_cause));
        chk("R10", "evec", evec_q, m_evec);
        chk("R11", "count", 64'(count_q), 64'(m_cnt));
        chk("R2", "running", 64'(running), 64'(m_run));
    endtask

    task automatic model_step();
        logic [CNT_W:0] sum;
        logic           fire, tk;
        logic [7:0]     setv, clrv, live;
        tk   = exp_take();
        live = m_pend & m_st[11:4];
        sum  = {1'b0, m_cnt} + (CNT_W+1)'(cnt_step);
        fire = !cnt_wr && (m_cnt < m_cmp) && (sum >= {1'b0, m_cmp});
        setv = irq_set | (8'(fire) << 7) | (8'(ipi_deliver) << 5);
        clrv = irq_clr | (8'(cmp_wr) << 7);
        if (tk) begin
            m_st    = {m_st[11:3], m_st[1], 1'b1, 1'b0};
            m_epc   = m_pc;
            m_pc    = m_evec;
            m_cause = 8'(BASE + low_idx(live));
            m_bad   = fault_addr;
        end else begin
            if (status_wr) m_st = status_wdata;
            if (pc_upd)    m_pc = pc_next;
        end
        if (evec_wr) m_evec = evec_wdata;
        m_pend = (m_pend & ~clrv) | setv;
        if (ipi_deliver) m_run = 1'b1;
        m_cnt = cnt_wr ? cnt_wdata : sum[CNT_W-1:0];
        if (cmp_wr) m_cmp = cmp_wdata;
    endtask

    task automatic idle();
        cnt_step = '0; cnt_wr = 0; cmp_wr = 0; irq_set = '0; irq_clr = '0;
        ipi_deliver = 0; status_wr = 0; evec_wr = 0; pc_upd = 0;
    endtask

    // inputs are driven before the call; the call advances one edge and checks
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        idle();
    endtask

    initial begin
        #(5.0 * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20111));
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_pend = '0; m_st = 12'hFFB; m_pc = '0; m_epc = '0; m_bad = '0;
        m_evec = 64'h2000; m_cause = '0; m_cnt = '0; m_cmp = '0; m_run = 0;
        // R1: reset state
        chk("R1", "status", 64'(status_q), 64'hFFB);
        chk("R1", "evec", evec_q, 64'h2000);
        chk("R1", "pc", pc_q, 64'h0);
        chk("R1", "cause", 64'(cause_q), 64'h0);
        chk("R1", "pending", 64'(pending_q), 64'h0);
        chk("R1", "running", 64'(running), 64'h0);
        compare_all();

        // R2: boot through an IPI
        ipi_deliver = 1; fault_addr = 64'hBAD0; cyc();
        chk("R2", "ipi pending", 64'(pending_q), 64'h20);
        chk("R3", "boot take", 64'(trap_take), 64'h1);
        cyc();
        chk("R6", "boot pc", pc_q, 64'h2000);
        chk("R4", "boot cause", 64'(cause_q), 64'(BASE + 5));
        chk("R5", "boot status", 64'(status_q), 64'hFFE);

        // R8 clear IPI; timer exact hit with interrupts masked
        irq_clr = 8'h20; status_wr = 1; status_wdata = 12'h00F;
        cnt_wr = 1; cnt_wdata = 100; cmp_wr = 1; cmp_wdata = 110; cyc();
        chk("R8", "ipi cleared", 64'(pending_q), 64'h0);
        cnt_step = 10; cyc();
        chk("R7", "exact hit", 64'(pending_q[7]), 64'h1);
        repeat (3) cyc();
        chk("R9", "masked hold", 64'(pending_q[7]), 64'h1);
        chk("R9", "masked no take", 64'(trap_take), 64'h0);

        // R7: starting at compare does not fire
        cmp_wr = 1; cmp_wdata = 110; cnt_wr = 1; cnt_wdata = 110; cyc();
        chk("R8", "compare write clears", 64'(pending_q[7]), 64'h0);
        cnt_step = 5; cyc();
        chk("R7", "equal start", 64'(pending_q[7]), 64'h0);

        // R7: large step jumps past
        cnt_wr = 1; cnt_wdata = 100; cmp_wr = 1; cmp_wdata = 110; cyc();
        cnt_step = 200; cyc();
        chk("R7", "jump past", 64'(pending_q[7]), 64'h1);

        // R7 wrap, R11 count
        cnt_wr = 1; cnt_wdata = 32'hFFFF_FFF0; cmp_wr = 1; cmp_wdata = 32'hFFFF_FFF8; cyc();
        cnt_step = 255; cyc();
        chk("R7", "wrap crossing", 64'(pending_q[7]), 64'h1);
        chk("R11", "wrapped count", 64'(count_q), 64'hEF);

        // R4 priority
        irq_clr = 8'h80; status_wr = 1; status_wdata = 12'hFFF; cyc();
        irq_set = 8'hA4; cyc();
        chk("R3", "take with three", 64'(trap_take), 64'h1);
        cyc();
        chk("R4", "lowest wins", 64'(cause_q), 64'(BASE + 2));

        // R8 set beats clear
        irq_set = 8'h08; irq_clr = 8'h08; cyc();
        chk("R8", "set wins", 64'(pending_q[3]), 64'h1);

        // R10 writes colliding with trap entry; evec write
        evec_wr = 1; evec_wdata = 64'h8000; status_wr = 1; status_wdata = 12'hFFF; cyc();
        chk("R10", "evec write", evec_q, 64'h8000);
        pc_upd = 1; pc_next = 64'h1234; status_wr = 1; status_wdata = 12'h001; cyc();
        chk("R10", "trap beats pc write", pc_q, 64'h8000);
        chk("R10", "trap beats status write", 64'(status_q), 64'hFFE);

        irq_clr = 8'hFF; cyc();

        // seeded random phase
        for (int n = 0; n < 3000; n++) begin
            cnt_step = 8'($urandom % 16);
            if ($urandom % 8 == 0) irq_set = 8'($urandom);
            if ($urandom % 8 == 0) irq_clr = 8'($urandom);
            ipi_deliver = ($urandom % 16 == 0);
            if ($urandom % 12 == 0) begin status_wr = 1; status_wdata = 12'($urandom); end
            if ($urandom % 32 == 0) begin evec_wr = 1; evec_wdata = {32'h0, $urandom} & ~64'h3; end
            pc_upd = $urandom % 2; pc_next = {$urandom, $urandom};
            fault_addr = {$urandom, $urandom};
            if ($urandom % 32 == 0) begin cnt_wr = 1; cnt_wdata = $urandom; end
            if ($urandom % 16 == 0) begin cmp_wr = 1; cmp_wdata = m_cnt + 32'($urandom % 64); end
            cyc();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule